// File: doc/BRIEF.md
# Dual External Interrupt Edge Detector

This block turns two external interrupt pins into latched request flags for an interrupt controller. Channel A has a programmable edge sense: rising only, falling only, or both edges. Its pin first passes through a synchronizer and then a digital glitch filter that runs on a sampling-clock enable, so a level counts only once it has held through several sampling ticks. Channel B always senses rising edges. Its pin drives the clock of a capture flop directly, so a pulse is remembered even while the system clock is stopped. That flop's output is resynchronized and raises the request once the clock runs again.

Each request flag stays set until software pulses its clear input for one cycle. If a new edge arrives in the same cycle as a clear, the edge wins. Writing the edge-mode register only changes which filtered transitions count. Edge detection works on the filter's own transitions, never on a stored pin level, so a mode write cannot produce a request by itself.

The channel A filter is a four-state machine. The states are `F_LOW` and `F_HIGH` (settled levels) and `F_PEND_RISE` and `F_PEND_FALL` (candidate new level, counting ticks). The transitions are:
- `F_LOW` to `F_PEND_RISE` on a tick that samples high.
- `F_PEND_RISE` to `F_HIGH` on the tick that completes the stable count (rise event).
- `F_PEND_RISE` back to `F_LOW` on a tick that samples low.
- `F_HIGH` to `F_PEND_FALL`, `F_PEND_FALL` to `F_LOW` (fall event) and `F_PEND_FALL` back to `F_HIGH`, by symmetry.

The channel B capture has two states. `C_ARMED` moves to `C_RETIRE` when the synchronized capture is seen, and that move raises the event. `C_RETIRE` holds the capture flop cleared and returns to `C_ARMED` once the synchronized copy reads low. Reset enters `C_RETIRE`.

Top module: `xint_edge_unit`

## Requirements
- R1: The edge-mode register resets to rising. A write with `mode_wdata` 2'b00 selects rising, 2'b01 selects falling, and 2'b10 or 2'b11 selects both edges.
- R2: The channel A filter accepts a new level only after that level has been sampled on 3 consecutive `samp_tick` cycles. A pulse covering fewer ticks raises no request.
- R3: In rising or both mode, an accepted low-to-high transition on channel A sets `req_a`.
- R4: In falling or both mode, an accepted high-to-low transition on channel A sets `req_a`. In rising mode it does not.
- R5: A write to the edge-mode register while the channel A input is steady never sets `req_a`.
- R6: A rising edge on `ext_b_in` sets `req_b`. A falling edge does not.
- R7: A rising edge on `ext_b_in` that occurs while `clk` is stopped sets `req_b` after the clock resumes.
- R8: A request flag stays set until a one-cycle clear pulse, and the clear resets it.
- R9: A new event in the same cycle as a clear leaves the flag set.
- R10: Reset clears both request flags.
- R11: Without `samp_tick` the filtered level of channel A never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Edge-mode register write strobe |
| mode_wdata | input | 2 | Edge-mode value (see R1) |
| samp_tick | input | 1 | Sampling-clock enable for the channel A filter |
| ext_a_in | input | 1 | Raw channel A interrupt pin |
| ext_b_in | input | 1 | Raw channel B interrupt pin, asynchronous |
| clr_a | input | 1 | One-cycle clear of `req_a` |
| clr_b | input | 1 | One-cycle clear of `req_b` |
| req_a | output | 1 | Channel A request flag |
| req_b | output | 1 | Channel B request flag |

## Verification
The assertions check the following on every cycle:
- Both flags obey set-over-clear priority and hold their state.
- `req_a` never rises without a qualified filter event.
- The filtered level stays frozen on cycles without a sampling tick.

Only the bench scenarios can show the rest:
- The tick-count boundary of the filter, swept over several tick periods.
- The mode encodings, and that mode writes do not trigger requests.
- That a channel B pulse given while the clock is fully stopped still becomes a request.

// File: rtl/xint_pkg.sv
`timescale 1ns/1ps
package xint_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE     = 2'b00,
        EDGE_FALL     = 2'b01,
        EDGE_BOTH     = 2'b10,
        EDGE_BOTH_ALT = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        F_LOW       = 2'b00,
        F_PEND_RISE = 2'b01,
        F_HIGH      = 2'b10,
        F_PEND_FALL = 2'b11
    } filt_state_e;

    typedef enum logic {
        C_ARMED  = 1'b0,
        C_RETIRE = 1'b1
    } catch_state_e;

endpackage

// File: rtl/xint_sync.sv
`timescale 1ns/1ps
module xint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xint_glitch_filter.sv
`timescale 1ns/1ps
module xint_glitch_filter
    import xint_pkg::*;
#(
    parameter int STABLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic level,
    output logic rise_p,
    output logic fall_p
);
    localparam int CNT_W = $clog2(STABLE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    filt_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              level_q, rise_q, fall_q;

    // next-state logic: a candidate level must survive STABLE_TICKS samples
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            F_LOW: begin
                if (tick && din) begin
                    state_d = F_PEND_RISE;
                    cnt_d   = CNT_ONE;
                end
            end
            F_PEND_RISE: begin
                if (tick) begin
                    if (!din) begin
                        state_d = F_LOW;
                        cnt_d   = '0;
                    end else if (cnt_q == CNT_LAST) begin
                        state_d = F_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_q + CNT_ONE;
                    end
                end
            end
            F_HIGH: begin
                if (tick && !din) begin
                    state_d = F_PEND_FALL;
                    cnt_d   = CNT_ONE;
                end
            end
            F_PEND_FALL: begin
                if (tick) begin
                    if (din) begin
                        state_d = F_HIGH;
                        cnt_d   = '0;
                    end else if (cnt_q == CNT_LAST) begin
                        state_d = F_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_q + CNT_ONE;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= F_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs: settled level and one-cycle transition pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            level_q <= (state_d == F_HIGH) || (state_d == F_PEND_FALL);
            rise_q  <= (state_q == F_PEND_RISE) && (state_d == F_HIGH);
            fall_q  <= (state_q == F_PEND_FALL) && (state_d == F_LOW);
        end
    end

    assign level  = level_q;
    assign rise_p = rise_q;
    assign fall_p = fall_q;
endmodule

// File: rtl/xint_async_catch.sv
`timescale 1ns/1ps
module xint_async_catch
    import xint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic event_o
);
    catch_state_e state_q, state_d;
    logic         cap_q;
    logic         cap_s;
    logic         retire;

    assign retire = (state_q == C_RETIRE);

    // capture flop clocked by the pin itself; works with clk stopped
    always_ff @(posedge pin or posedge retire) begin
        if (retire) cap_q <= 1'b0;
        else        cap_q <= 1'b1;
    end

    xint_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cap_q),
        .q     (cap_s)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_ARMED:  if (cap_s)  state_d = C_RETIRE;
            C_RETIRE: if (!cap_s) state_d = C_ARMED;
        endcase
    end

    // state register; reset parks in C_RETIRE so the capture starts cleared
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_RETIRE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        event_o = (state_q == C_ARMED) && cap_s;
    end
endmodule

// File: rtl/xint_req_flag.sv
`timescale 1ns/1ps
module xint_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // a set arriving with a clear takes precedence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/xint_edge_unit.sv
`timescale 1ns/1ps
module xint_edge_unit
    import xint_pkg::*;
#(
    parameter int STABLE_TICKS = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [1:0] mode_wdata,
    input  logic       samp_tick,
    input  logic       ext_a_in,
    input  logic       ext_b_in,
    input  logic       clr_a,
    input  logic       clr_b,
    output logic       req_a,
    output logic       req_b
);
    edge_mode_e mode_q;
    logic       a_s;
    logic       filt_level;
    logic       filt_rise;
    logic       filt_fall;
    logic       a_evt;
    logic       b_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= EDGE_RISE;
        else if (mode_we) mode_q <= edge_mode_e'(mode_wdata);
    end

    xint_sync #(.STAGES(SYNC_STAGES)) u_a_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_a_in),
        .q     (a_s)
    );

    xint_glitch_filter #(.STABLE_TICKS(STABLE_TICKS)) u_a_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (samp_tick),
        .din    (a_s),
        .level  (filt_level),
        .rise_p (filt_rise),
        .fall_p (filt_fall)
    );

    // edge qualification uses filter transitions only, so mode writes are harmless
    always_comb begin
        unique case (mode_q)
            EDGE_RISE:     a_evt = filt_rise;
            EDGE_FALL:     a_evt = filt_fall;
            EDGE_BOTH,
            EDGE_BOTH_ALT: a_evt = filt_rise || filt_fall;
        endcase
    end

    xint_async_catch #(.SYNC_STAGES(SYNC_STAGES)) u_b_catch (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (ext_b_in),
        .event_o (b_evt)
    );

    xint_req_flag u_flag_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (a_evt),
        .clr_i  (clr_a),
        .flag_o (req_a)
    );

    xint_req_flag u_flag_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (b_evt),
        .clr_i  (clr_b),
        .flag_o (req_b)
    );
endmodule

// File: rtl/xint_edge_unit_chk.sv
`timescale 1ns/1ps
module xint_edge_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic samp_tick,
    input logic clr_a,
    input logic clr_b,
    input logic req_a,
    input logic req_b,
    input logic a_evt,
    input logic b_evt,
    input logic filt_level
);
    p_set_wins_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        a_evt |=> req_a);

    p_set_wins_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        b_evt |=> req_b);

    p_clear_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && !a_evt) |=> !req_a);

    p_hold_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_a && !clr_a) |=> req_a);

    p_hold_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_b && !clr_b) |=> req_b);

    p_quiet_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_a && !a_evt) |=> !req_a);

    p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_tick |=> $stable(filt_level));
endmodule

bind xint_edge_unit xint_edge_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_tick  (samp_tick),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .req_a      (req_a),
    .req_b      (req_b),
    .a_evt      (a_evt),
    .b_evt      (b_evt),
    .filt_level (filt_level)
);

// File: tb/xint_edge_unit_test.sv
`timescale 1ns/1ps
module xint_edge_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int STABLE     = 3;

    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n;
    logic       mode_we;
    logic [1:0] mode_wdata;
    logic       samp_tick;
    logic       ext_a_in;
    logic       ext_b_in;
    logic       clr_a;
    logic       clr_b;
    logic       req_a;
    logic       req_b;

    int checks = 0;
    int errors = 0;
    int tick_per = 1;
    int tick_cnt = 0;
    bit done = 0;

    xint_edge_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .samp_tick  (samp_tick),
        .ext_a_in   (ext_a_in),
        .ext_b_in   (ext_b_in),
        .clr_a      (clr_a),
        .clr_b      (clr_b),
        .req_a      (req_a),
        .req_b      (req_b)
    );

    initial begin
        forever begin
            #(CLK_PERIOD / 2);
            if (clk_run) clk = ~clk;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            samp_tick = (tick_per != 0) && (tick_cnt == 0);
            if (tick_per != 0) tick_cnt = (tick_cnt + 1 >= tick_per) ? 0 : tick_cnt + 1;
        end
    endtask

    task automatic write_mode(input logic [1:0] m);
        mode_wdata = m;
        mode_we    = 1'b1;
        step(1);
        mode_we    = 1'b0;
    endtask

    task automatic pulse_clr_a();
        clr_a = 1'b1;
        step(1);
        clr_a = 1'b0;
    endtask

    task automatic pulse_clr_b();
        clr_b = 1'b1;
        step(1);
        clr_b = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_we = 1'b0; mode_wdata = 2'b00; samp_tick = 1'b0;
        ext_a_in = 1'b0; ext_b_in = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
        step(4);
        chk("R10 req_a after reset", req_a, 1'b0);
        chk("R10 req_b after reset", req_b, 1'b0);
        rst_n = 1'b1;
        step(6);

        // R1: default mode is rising
        ext_a_in = 1'b1; step(20);
        chk("R1 reset mode rising: rise sets", req_a, 1'b1);
        pulse_clr_a();
        ext_a_in = 1'b0; step(20);
        chk("R1 reset mode rising: fall ignored", req_a, 1'b0);

        // R3 / R4: every mode encoding against both transitions
        for (int m = 0; m < 4; m++) begin
            write_mode(2'(m));
            step(4);
            ext_a_in = 1'b1; step(20);
            chk("R3 rise under mode", req_a, (m != 1));
            pulse_clr_a();
            chk("R8 clear after rise", req_a, 1'b0);
            ext_a_in = 1'b0; step(20);
            chk("R4 fall under mode", req_a, (m != 0));
            pulse_clr_a();
        end

        // R8: flag holds without a clear
        write_mode(2'b00);
        ext_a_in = 1'b1; step(20);
        step(30);
        chk("R8 flag held", req_a, 1'b1);
        pulse_clr_a();
        chk("R8 flag cleared", req_a, 1'b0);

        // R5: mode writes with steady high input
        for (int m = 1; m < 5; m++) begin
            write_mode(2'(m % 4));
            step(10);
            chk("R5 mode write no request", req_a, 1'b0);
        end
        write_mode(2'b00);
        ext_a_in = 1'b0; step(20);
        pulse_clr_a();

        // R2: pulse of k tick periods is accepted only if k >= STABLE
        write_mode(2'b10);
        for (int p = 1; p <= 4; p++) begin
            tick_per = p; tick_cnt = 0;
            for (int k = 1; k <= 5; k++) begin
                step(8);
                pulse_clr_a();
                ext_a_in = 1'b1; step(k * p);
                ext_a_in = 1'b0; step(40);
                chk("R2 pulse width vs tick count", req_a, (k >= STABLE));
                pulse_clr_a();
            end
        end

        // R11: no sampling ticks means no filtered change
        tick_per = 0; samp_tick = 1'b0;
        ext_a_in = 1'b1; step(30);
        chk("R11 no tick no rise", req_a, 1'b0);
        ext_a_in = 1'b0; step(10);
        tick_per = 1; tick_cnt = 0; step(20);
        chk("R11 low again no event", req_a, 1'b0);

        // R6: channel B rising edge only
        ext_b_in = 1'b1; step(10);
        chk("R6 rise on B sets", req_b, 1'b1);
        pulse_clr_b();
        chk("R8 clear B", req_b, 1'b0);
        ext_b_in = 1'b0; step(10);
        chk("R6 fall on B ignored", req_b, 1'b0);

        // R9: event and clear in the same cycle; event lands on the third edge
        @(negedge clk); ext_b_in = 1'b1;
        @(negedge clk);
        @(negedge clk); clr_b = 1'b1;
        @(negedge clk); clr_b = 1'b0;
        chk("R9 set beats clear", req_b, 1'b1);
        step(5);
        pulse_clr_b();
        ext_b_in = 1'b0; step(10);
        chk("R9 cleared afterwards", req_b, 1'b0);

        // R7: pulse while the clock is stopped
        @(negedge clk);
        clk_run = 1'b0;
        #(CLK_PERIOD * 3);
        ext_b_in = 1'b1;
        #2;
        ext_b_in = 1'b0;
        #(CLK_PERIOD * 3);
        chk("R7 no update while stopped", req_b, 1'b0);
        clk_run = 1'b1;
        step(8);
        chk("R7 captured while stopped", req_b, 1'b1);
        pulse_clr_b();

        // R10: reset clears set flags
        ext_a_in = 1'b1; ext_b_in = 1'b1; step(20);
        rst_n = 1'b0; step(2);
        chk("R10 req_a cleared by reset", req_a, 1'b0);
        chk("R10 req_b cleared by reset", req_b, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule